// File: doc/BRIEF.md
# Far-End Alarm Code Receiver

This block watches a single overhead bit stream, taking one bit on each cycle where the bit-valid strobe is high. It looks for 16-bit alarm or command code words. A word is framed by a run of ones and two zero marker bits, and it carries a 6-bit code. The receiver hunts for a word one bit position at a time. Once it finds a candidate, it locks to 16-bit slots. It declares a code valid when the same code fills three slots in a row. It declares the code gone when two slots in a row fail to carry it.

Each time a code is validated, the block sets a sticky detect flag and queues the 6-bit code in a four-entry FIFO. The host reads the FIFO through a show-ahead port and a read strobe. If the FIFO is already full, the new code is dropped and a sticky overflow flag is raised. An interrupt is raised while either flag is set, provided the host enables it. A receive-reset input empties the FIFO, clears both flags and sends the detector back to searching. Framing of the line and extraction of the overhead bit are handled upstream.

Top module: `alm_code_rx`

## Requirements
- R1: A word is accepted from any bit offset in the stream. The earliest-arriving bit is counted as bit 0. Bits 0..7 must be ones, bit 8 and bit 15 must be zeros, and bits 9..14 carry the code, with bit 9 as the code LSB.
- R2: A code is validated only when the same code appears in three consecutive 16-bit slots. When validation happens, `code_active` rises on the clock edge that samples the last bit of the third word.
- R3: While a code is active, a single bad slot keeps it active. Two consecutive slots that do not carry that code clear `code_active` on the edge that samples the last bit of the second bad slot. The detector then searches bit by bit again.
- R4: Each validation writes exactly one FIFO entry. No further entry is written while the code stays active.
- R5: The FIFO holds four codes and presents its oldest code on `fifo_code`. `fifo_empty` is high when it holds none. A `rd_strobe` while the FIFO is not empty removes the oldest entry on that edge.
- R6: If a validation finds the FIFO full (counted before any read on the same edge), the new code is dropped. `ovf_stat` is then set and stays set until a clear strobe or a receive reset.
- R7: `det_stat` is set on every validation and cleared by `clr_strobe`. If a set and a clear occur on the same edge, the set wins.
- R8: `irq` is high exactly when `irq_en` is high and `det_stat` or `ovf_stat` is high.
- R9: `rx_reset` empties the FIFO, clears both status bits and `code_active`, and restarts the bit-by-bit search on the next edge.
- R10: Bits are taken only on cycles where `bit_en` is high. `bit_in` has no effect on any other cycle.
- R11: While a code is awaiting validation, a well-formed word that carries a different code restarts the count at one for that new code. A malformed word sends the detector back to bit-by-bit search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Serial overhead bit |
| bit_en | input | 1 | Marks `bit_in` as valid this cycle |
| rd_strobe | input | 1 | Pops the oldest FIFO entry |
| clr_strobe | input | 1 | Clears the detect and overflow status |
| rx_reset | input | 1 | Receive reset: flushes FIFO, status and detector |
| irq_en | input | 1 | Interrupt enable |
| fifo_code | output | 6 | Oldest queued code (show-ahead) |
| fifo_empty | output | 1 | FIFO holds no code |
| det_stat | output | 1 | Sticky code-validated status |
| ovf_stat | output | 1 | Sticky FIFO overflow status |
| code_active | output | 1 | A validated code is currently present |
| irq | output | 1 | Interrupt request |

## Verification
Validation, release, FIFO writes and status changes all appear on the same clock edge that samples the deciding bit. That bit is the last bit of the third matching word, or the last bit of the second bad slot. Reads, clears and receive resets take effect on the edge that samples the strobe, and `irq` follows the registered status within that same cycle. The bench drives inputs on the falling edge. It advances a behavioural model on each rising edge and compares every output 2 ns after that edge, so each result is checked in the exact cycle it is due. Directed checks taken at the following falling edge confirm the boundary cases, including bit offsets, strobe gaps, a single bad slot, overflow order and simultaneous set and clear.

// File: rtl/alm_code_pkg.sv
// Package: shared constants and types for the alarm code receiver.
// Assumes a word of LEAD_W ones, one zero, CODE_W code bits, one zero.
package alm_code_pkg;
    localparam int LEAD_W   = 8;
    localparam int CODE_W   = 6;
    localparam int WORD_W   = LEAD_W + CODE_W + 2;
    localparam int CODE_LSB = LEAD_W + 1;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_CAND   = 2'd1,
        ST_LOCK   = 2'd2
    } trk_state_e;
endpackage

// File: rtl/alm_code_shifter.sv
// Shifter: holds the last WORD_W received bits, with the earliest-arrived bit
// at index 0. Evaluates the window as it will look after the current bit.
// Assumes the caller only acts on hit/code when bit_en is high.
module alm_code_shifter
    import alm_code_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              bit_en,
    input  logic              bit_in,
    output logic              hit,
    output logic [CODE_W-1:0] code
);
    logic [WORD_W-1:0] win_q;
    logic [WORD_W-1:0] win_d;
    logic [LEAD_W-1:0] lead_ok;

    assign win_d = {bit_in, win_q[WORD_W-1:1]};

    // Per-bit check of the leading run of ones.
    for (genvar g = 0; g < LEAD_W; g++) begin : g_lead
        assign lead_ok[g] = win_d[g];
    end

    // Match on the ones run plus both zero markers.
    always_comb begin
        hit  = (&lead_ok) && !win_d[LEAD_W] && !win_d[WORD_W-1];
        code = win_d[CODE_LSB +: CODE_W];
    end

    // Window register, cleared to zeros so no false match before WORD_W bits.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            win_q <= '0;
        end else if (bit_en) begin
            win_q <= win_d;
        end
    end
endmodule

// File: rtl/alm_code_tracker.sv
// Tracker: bit-by-bit search, slot-locked validation over HIT_N words and
// release after MISS_N bad slots. Raises push for one cycle per validation.
// Assumes WORD_W is a power of two so the slot counter wraps naturally.
module alm_code_tracker
    import alm_code_pkg::*;
#(
    parameter int HIT_N  = 3,
    parameter int MISS_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              bit_en,
    input  logic              hit,
    input  logic [CODE_W-1:0] code,
    output logic              push,
    output logic [CODE_W-1:0] push_code,
    output logic              active
);
    localparam int PW = $clog2(WORD_W);
    localparam int HW = $clog2(HIT_N + 1);
    localparam int MW = $clog2(MISS_N + 1);

    trk_state_e        state_q;
    logic [PW-1:0]     pos_q;
    logic [HW-1:0]     hits_q;
    logic [MW-1:0]     miss_q;
    logic [CODE_W-1:0] cand_q;
    logic              slot_end;
    logic              same;

    // Slot boundary and same-code decode for the current bit.
    always_comb begin
        slot_end  = bit_en && (pos_q == PW'(WORD_W - 1));
        same      = hit && (code == cand_q);
        push      = slot_end && (state_q == ST_CAND) && same && (hits_q == HW'(HIT_N - 1));
        push_code = cand_q;
        active    = (state_q == ST_LOCK);
    end

    // Detector state machine, advanced once per valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            state_q <= ST_SEARCH;
            pos_q   <= '0;
            hits_q  <= '0;
            miss_q  <= '0;
            cand_q  <= '0;
        end else if (bit_en) begin
            case (state_q)
                ST_SEARCH: begin
                    if (hit) begin
                        state_q <= ST_CAND;
                        cand_q  <= code;
                        hits_q  <= HW'(1);
                        pos_q   <= '0;
                    end
                end
                ST_CAND: begin
                    pos_q <= pos_q + 1'b1;
                    if (slot_end) begin
                        if (same) begin
                            if (hits_q == HW'(HIT_N - 1)) begin
                                state_q <= ST_LOCK;
                                miss_q  <= '0;
                            end else begin
                                hits_q <= hits_q + 1'b1;
                            end
                        end else if (hit) begin
                            cand_q <= code;
                            hits_q <= HW'(1);
                        end else begin
                            state_q <= ST_SEARCH;
                        end
                    end
                end
                ST_LOCK: begin
                    pos_q <= pos_q + 1'b1;
                    if (slot_end) begin
                        if (same) begin
                            miss_q <= '0;
                        end else if (miss_q == MW'(MISS_N - 1)) begin
                            state_q <= ST_SEARCH;
                        end else begin
                            miss_q <= miss_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_SEARCH;
            endcase
        end
    end
endmodule

// File: rtl/alm_code_fifo.sv
// FIFO: DEPTH-entry show-ahead queue of codes. A write is refused when the
// queue is full before any same-edge read; the caller flags the loss.
module alm_code_fifo
    import alm_code_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr,
    input  logic [CODE_W-1:0] wr_data,
    input  logic              rd,
    output logic [CODE_W-1:0] rd_data,
    output logic              empty,
    output logic              full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [CODE_W-1:0] mem_q [DEPTH];
    logic [AW-1:0]     wp_q;
    logic [AW-1:0]     rp_q;
    logic [CW-1:0]     cnt_q;
    logic              do_wr;
    logic              do_rd;

    // Occupancy flags and accepted operations.
    always_comb begin
        empty   = (cnt_q == '0);
        full    = (cnt_q == CW'(DEPTH));
        do_wr   = wr && !full;
        do_rd   = rd && !empty;
        rd_data = mem_q[rp_q];
    end

    // Pointer and count update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_wr) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (do_rd) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            if (do_wr && !do_rd)      cnt_q <= cnt_q + 1'b1;
            else if (do_rd && !do_wr) cnt_q <= cnt_q - 1'b1;
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (do_wr) begin
            mem_q[wp_q] <= wr_data;
        end
    end
endmodule

// File: rtl/alm_code_rx.sv
// Top: far-end alarm code receiver. Chains shifter, tracker and FIFO, and
// holds the sticky detect and overflow status that drive the interrupt.
// Assumes one overhead bit per bit_en strobe, already extracted upstream.
module alm_code_rx
    import alm_code_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int HIT_N  = 3,
    parameter int MISS_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_en,
    input  logic              rd_strobe,
    input  logic              clr_strobe,
    input  logic              rx_reset,
    input  logic              irq_en,
    output logic [CODE_W-1:0] fifo_code,
    output logic              fifo_empty,
    output logic              det_stat,
    output logic              ovf_stat,
    output logic              code_active,
    output logic              irq
);
    logic              win_hit;
    logic [CODE_W-1:0] win_code;
    logic              push;
    logic [CODE_W-1:0] push_code;
    logic              fifo_full;

    alm_code_shifter u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (rx_reset),
        .bit_en (bit_en),
        .bit_in (bit_in),
        .hit    (win_hit),
        .code   (win_code)
    );

    alm_code_tracker #(.HIT_N(HIT_N), .MISS_N(MISS_N)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_reset),
        .bit_en    (bit_en),
        .hit       (win_hit),
        .code      (win_code),
        .push      (push),
        .push_code (push_code),
        .active    (code_active)
    );

    alm_code_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (rx_reset),
        .wr      (push),
        .wr_data (push_code),
        .rd      (rd_strobe),
        .rd_data (fifo_code),
        .empty   (fifo_empty),
        .full    (fifo_full)
    );

    // Sticky status: set has priority over the host clear.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_reset) begin
            det_stat <= 1'b0;
            ovf_stat <= 1'b0;
        end else begin
            if (push)            det_stat <= 1'b1;
            else if (clr_strobe) det_stat <= 1'b0;
            if (push && fifo_full) ovf_stat <= 1'b1;
            else if (clr_strobe)   ovf_stat <= 1'b0;
        end
    end

    // Interrupt request from enabled status.
    always_comb irq = irq_en && (det_stat || ovf_stat);
endmodule

// File: rtl/alm_code_rx_chk.sv
// Checker: temporal properties of the alarm code receiver, bound to the top.
module alm_code_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic rd_strobe,
    input logic clr_strobe,
    input logic rx_reset,
    input logic irq_en,
    input logic fifo_empty,
    input logic det_stat,
    input logic ovf_stat,
    input logic code_active,
    input logic irq
);
    // R9
    rx_reset_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reset |=> (fifo_empty && !det_stat && !ovf_stat && !code_active));

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_stat && !clr_strobe && !rx_reset) |=> ovf_stat);

    // R10
    no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !rx_reset) |=> $stable(code_active));

    // R2
    det_on_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(code_active) |-> det_stat);

    // R4
    fifo_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(code_active) |-> (!fifo_empty || ovf_stat));

    // R5
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_empty && !bit_en) |=> fifo_empty);

    // R8
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && $rose(det_stat)) |-> irq);

    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en) |-> !irq);
endmodule

bind alm_code_rx alm_code_rx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .rd_strobe   (rd_strobe),
    .clr_strobe  (clr_strobe),
    .rx_reset    (rx_reset),
    .irq_en      (irq_en),
    .fifo_empty  (fifo_empty),
    .det_stat    (det_stat),
    .ovf_stat    (ovf_stat),
    .code_active (code_active),
    .irq         (irq)
);

// File: tb/alm_code_rx_tb.sv
module alm_code_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b1;
    logic       bit_en = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       clr_strobe = 1'b0;
    logic       rx_reset = 1'b0;
    logic       irq_en = 1'b0;
    logic [5:0] fifo_code;
    logic       fifo_empty;
    logic       det_stat;
    logic       ovf_stat;
    logic       code_active;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;
    int gap     = 0;
    bit done    = 0;

    // reference model state
    bit bq[$];
    int fq[$];
    int m_state = 0;   // 0 search, 1 candidate, 2 locked
    int m_pos   = 0;
    int m_hits  = 0;
    int m_miss  = 0;
    int m_cand  = 0;
    bit m_det   = 0;
    bit m_ovf   = 0;

    always #4 clk = ~clk;

    alm_code_rx u_dut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_en(bit_en),
        .rd_strobe(rd_strobe), .clr_strobe(clr_strobe), .rx_reset(rx_reset),
        .irq_en(irq_en), .fifo_code(fifo_code), .fifo_empty(fifo_empty),
        .det_stat(det_stat), .ovf_stat(ovf_stat), .code_active(code_active),
        .irq(irq)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R1 word format: oldest bit first; 8 ones, zero, code LSB first, zero
    function automatic bit word_ok(output int c);
        c = 0;
        if (bq.size() != 16) return 0;
        for (int i = 0; i < 8; i++) if (bq[i] != 1'b1) return 0;
        if (bq[8] != 1'b0 || bq[15] != 1'b0) return 0;
        for (int i = 0; i < 6; i++) c += int'(bq[9+i]) << i;
        return 1;
    endfunction

    task automatic model_step();
        bit pv;
        bit full_pre;
        bit h;
        int c;
        if (!rst_n || rx_reset) begin
            bq.delete(); fq.delete();
            m_state = 0; m_pos = 0; m_hits = 0; m_miss = 0; m_cand = 0;
            m_det = 0; m_ovf = 0;
            return;
        end
        pv = 0;
        if (bit_en) begin
            bq.push_back(bit_in);
            if (bq.size() > 16) void'(bq.pop_front());
            h = word_ok(c);
            if (m_state == 0) begin
                if (h) begin m_state = 1; m_cand = c; m_hits = 1; m_pos = 0; end
            end else begin
                if (m_pos == 15) begin
                    if (m_state == 1) begin
                        if (h && c == m_cand) begin
                            if (m_hits == 2) begin m_state = 2; m_miss = 0; pv = 1; end
                            else m_hits++;
                        end else if (h) begin m_cand = c; m_hits = 1; end
                        else m_state = 0;
                    end else begin
                        if (h && c == m_cand) m_miss = 0;
                        else if (m_miss == 1) m_state = 0;
                        else m_miss++;
                    end
                end
                m_pos = (m_pos + 1) % 16;
            end
        end
        full_pre = (fq.size() == 4);
        if (rd_strobe && fq.size() > 0) void'(fq.pop_front());
        if (pv) begin
            if (!full_pre) fq.push_back(m_cand);
            else m_ovf = 1;
            m_det = 1;
        end
        if (clr_strobe) begin
            if (!pv) m_det = 0;
            if (!(pv && full_pre)) m_ovf = 0;
        end
    endtask

    // Model advances on each rising edge; outputs compared 2 ns later.
    always @(posedge clk) begin
        model_step();
        #2;
        if (!done) begin
            check("R3", "code_active", code_active, int'(m_state == 2));
            check("R5", "fifo_empty", fifo_empty, int'(fq.size() == 0));
            if (fq.size() > 0) check("R5", "fifo_code", fifo_code, fq[0]);
            check("R7", "det_stat", det_stat, m_det);
            check("R6", "ovf_stat", ovf_stat, m_ovf);
            check("R8", "irq", irq, int'(irq_en && (m_det || m_ovf)));
        end
    end

    // R10: bit_in toggles while bit_en is low
    task automatic send_bit(input bit b);
        bit_in = b; bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        for (int i = 0; i < gap; i++) begin
            bit_in = ~b;
            @(negedge clk);
        end
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic send_word(input int code);
        send_ones(8);
        send_bit(1'b0);
        for (int i = 0; i < 6; i++) send_bit(code[i]);
        send_bit(1'b0);
    endtask

    task automatic pulse_rd();
        rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic pulse_clr();
        clr_strobe = 1'b1; @(negedge clk); clr_strobe = 1'b0;
    endtask

    task automatic pulse_rxr();
        rx_reset = 1'b1; @(negedge clk); rx_reset = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "reset empty", fifo_empty, 1);
        check("R9", "reset active", code_active, 0);
        check("R7", "reset det", det_stat, 0);

        // R1: odd bit offset, three words validate
        send_ones(21);
        send_word(6'h15); send_word(6'h15);
        check("R2", "active after two words", code_active, 0);
        send_word(6'h15);
        check("R2", "active after three words", code_active, 1);
        check("R1", "code at head", fifo_code, 6'h15);
        check("R7", "det set", det_stat, 1);

        // R4: code stays present, no extra writes
        for (int i = 0; i < 5; i++) send_word(6'h15);
        pulse_rd();
        check("R4", "single entry", fifo_empty, 1);

        // R3: one bad slot keeps it, two release it
        send_ones(16);
        send_word(6'h15);
        check("R3", "one bad slot", code_active, 1);
        send_ones(32);
        check("R3", "two bad slots", code_active, 0);

        // R7/R8: irq gating and clear
        irq_en = 1'b0; @(negedge clk);
        check("R8", "irq masked", irq, 0);
        irq_en = 1'b1; @(negedge clk);
        check("R8", "irq enabled", irq, 1);
        pulse_clr();
        check("R7", "det cleared", det_stat, 0);
        check("R8", "irq dropped", irq, 0);

        // R2: a bad slot after two matches restarts
        gap = 2;
        send_word(6'h0A); send_word(6'h0A);
        send_ones(16);
        send_word(6'h0A);
        check("R2", "broken run", fifo_empty, 1);
        check("R2", "broken run active", code_active, 0);
        pulse_rxr();

        // R11: different well-formed code restarts count
        send_ones(3);
        send_word(6'h21); send_word(6'h21);
        send_word(6'h33); send_word(6'h33);
        check("R11", "not yet", fifo_empty, 1);
        send_word(6'h33);
        check("R11", "new code head", fifo_code, 6'h33);
        gap = 0;

        // R9: receive reset while locked
        pulse_rxr();
        check("R9", "active cleared", code_active, 0);
        check("R9", "fifo flushed", fifo_empty, 1);

        // R6: fifth code overflows, set wins over clear on same edge
        for (int k = 1; k <= 5; k++) begin
            send_word(k); send_word(k);
            if (k == 5) clr_strobe = 1'b1;
            send_word(k);
            clr_strobe = 1'b0;
            send_ones(32);
        end
        check("R6", "overflow set", ovf_stat, 1);
        check("R7", "det set wins", det_stat, 1);
        for (int k = 1; k <= 4; k++) begin
            check("R5", "fifo order", fifo_code, k);
            pulse_rd();
        end
        check("R5", "drained", fifo_empty, 1);
        check("R6", "overflow sticky", ovf_stat, 1);
        pulse_clr();
        check("R6", "overflow cleared", ovf_stat, 0);

        // Mixed random stream, model compare every clock
        for (int n = 0; n < 120; n++) begin
            gap = $urandom_range(0, 1);
            if ($urandom_range(0, 2) == 0) begin
                int c;
                c = $urandom_range(0, 63);
                for (int r = 0; r < $urandom_range(2, 4); r++) send_word(c);
            end else begin
                for (int b = 0; b < 10; b++) send_bit($urandom_range(0, 1));
            end
            if ($urandom_range(0, 7) == 0) pulse_rd();
            if ($urandom_range(0, 15) == 0) pulse_clr();
            if ($urandom_range(0, 40) == 0) pulse_rxr();
        end

        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule